// File: doc/BRIEF.md
# Pulsed Radar Gate Timing Generator

This block times one transmit/receive cycle of a monostatic pulsed radar from a single shared period. Each period starts with a transmit-enable pulse. After a programmable delay the block opens a receive gate, and a one-cycle strobe marks the gate's opening as the first range sample. All four timing values are counts of the timing clock. With a 250 MHz clock, one count is 4 ns, which gives sub-microsecond resolution.

Software loads a period, a transmit width, a gate delay and a gate width in one load cycle. The block checks the set at once. It rejects any set in which transmitter and receiver would overlap, or in which the gate would run past the end of the period. An accepted set takes effect only at the next period start. The sequence can free-run after a start request, or it can wait for an external trigger before each period. A stop request lets the current period finish.

Top module: `radar_gate_timer`

## Requirements
- R1: While running without trigger mode, a period of P counts repeats back to back. Counting from phase 0 in the cycle after the start request is sampled, phase p lasts one clock and phase P-1 is followed directly by phase 0.
- R2: `txEnable` is high for exactly phases 0 to W-1 of each period, where W is the transmit width. A width of 0 gives no transmit pulse.
- R3: `rxGate` is high for exactly phases D to D+G-1 of each period, where D is the gate delay and G is the gate width.
- R4: `rangeStrobe` is high for one cycle at phase D of each period when G is nonzero, in the cycle `rxGate` opens. When G is zero it never fires.
- R5: A load pulse (`cfgLoad` high for one cycle) is rejected in any of these cases: W is not below P; D is below W; the exact sum D+G is greater than P, with the sum computed without wrap-around. A rejection sets `cfgError` in the next cycle and leaves the block unconfigured. While unconfigured, a start request is ignored. A running sequence finishes its current period and then goes idle.
- R6: An accepted load clears `cfgError` in the next cycle and marks the block configured.
- R7: A set accepted while a period is running does not change that period. It is used from the next period start onward.
- R8: A stop request while running lets the current period complete. The block is idle from the cycle after phase P-1 of that period.
- R9: If `extTrigEn` is high at a start request or at a period end, the block waits with all outputs low. The period begins with phase 0 in the cycle after `extTrig` is sampled high. A stop request while waiting returns the block to idle, and a later trigger is then ignored.
- R10: After reset and whenever the block is idle or waiting, `txEnable`, `rxGate` and `rangeStrobe` are low. `cfgError` is low after reset.
- R11: `txEnable` and `rxGate` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | One-cycle strobe that offers the four timing values |
| cfgPeriod | input | CNT_W | Period P in clocks |
| cfgTxWidth | input | CNT_W | Transmit width W in clocks |
| cfgGateDelay | input | CNT_W | Gate delay D from period start, in clocks |
| cfgGateWidth | input | CNT_W | Gate width G in clocks |
| startReq | input | 1 | Start request, honoured only when idle and configured |
| stopReq | input | 1 | Stop request |
| extTrigEn | input | 1 | Selects trigger-per-period operation |
| extTrig | input | 1 | External trigger, level sampled each clock |
| txEnable | output | 1 | Transmit modulation pulse |
| rxGate | output | 1 | Receive gating pulse |
| rangeStrobe | output | 1 | One-cycle first-range-sample marker |
| cfgError | output | 1 | Last load was rejected |

## Verification
The assertions assume that `cfgLoad` never falls in the same cycle as a period start. They also assume that the external trigger and stop request are single-clock levels sampled like any other synchronous input. The stimulus drives every input on the falling edge. It issues loads only while idle or in the middle of a period, never on phase P-1. The random timing sets are drawn so that W < P, W <= D and D+G <= P, and the rejected sets are directed cases built to break exactly one of those rules. One of them breaks the rule only through wrap-around of a 32-bit sum.

// File: rtl/rgt_pkg.sv
package rgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } rgt_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startPeriod;  // load active timing, phase to 0
    logic advance;      // phase + 1
    logic gateOn;       // outputs may be driven this cycle
  } rgt_strobe_t;

endpackage

// File: rtl/rgt_cfg.sv
module rgt_cfg #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] inPeriod,
  input  logic [CNT_W-1:0] inTxWidth,
  input  logic [CNT_W-1:0] inGateDelay,
  input  logic [CNT_W-1:0] inGateWidth,
  output logic [CNT_W-1:0] pendPeriod,
  output logic [CNT_W-1:0] pendTxWidth,
  output logic [CNT_W-1:0] pendGateDelay,
  output logic [CNT_W-1:0] pendGateWidth,
  output logic             cfgReady,
  output logic             cfgError
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] gateEndWide;
  logic             txFits;
  logic             gateAfterTx;
  logic             gateFits;
  logic             setValid;

  // One spare bit keeps the gate end exact
  assign gateEndWide = {1'b0, inGateDelay} + {1'b0, inGateWidth};
  assign txFits      = inTxWidth < inPeriod;
  assign gateAfterTx = inGateDelay >= inTxWidth;
  assign gateFits    = gateEndWide <= {1'b0, inPeriod};
  assign setValid    = txFits && gateAfterTx && gateFits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPeriod    <= '0;
      pendTxWidth   <= '0;
      pendGateDelay <= '0;
      pendGateWidth <= '0;
      cfgReady      <= 1'b0;
      cfgError      <= 1'b0;
    end else if (cfgLoad) begin
      if (setValid) begin
        pendPeriod    <= inPeriod;
        pendTxWidth   <= inTxWidth;
        pendGateDelay <= inGateDelay;
        pendGateWidth <= inGateWidth;
        cfgReady      <= 1'b1;
        cfgError      <= 1'b0;
      end else begin
        cfgReady      <= 1'b0;
        cfgError      <= 1'b1;
      end
    end
  end

  AST_BAD_SET_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad && !setValid |=> cfgError && !cfgReady); // R5

  AST_GOOD_SET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad && setValid |=> !cfgError && cfgReady); // R6

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(pendPeriod) && $stable(pendGateDelay)); // R7

  AST_READY_SANE: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |-> pendTxWidth < pendPeriod); // R5

endmodule

// File: rtl/rgt_ctrl.sv
module rgt_ctrl
  import rgt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        extTrigEn,
  input  logic        extTrig,
  input  logic        cfgReady,
  input  logic        periodEnd,
  output rgt_strobe_t strobe
);

  rgt_state_e state;
  rgt_state_e stateNext;
  logic       stopPend;
  logic       endRun;

  // A finished period stops if asked to or if the set was rejected
  assign endRun = stopPend || stopReq || !cfgReady;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq && cfgReady) begin
          if (extTrigEn) begin
            stateNext = ST_ARMED;
          end else begin
            stateNext          = ST_RUN;
            strobe.startPeriod = 1'b1;
          end
        end
      end
      ST_ARMED: begin
        if (stopReq || !cfgReady) begin
          stateNext = ST_IDLE;
        end else if (extTrig) begin
          stateNext          = ST_RUN;
          strobe.startPeriod = 1'b1;
        end
      end
      ST_RUN: begin
        strobe.gateOn = 1'b1;
        if (periodEnd) begin
          if (endRun) begin
            stateNext = ST_IDLE;
          end else if (extTrigEn) begin
            stateNext = ST_ARMED;
          end else begin
            strobe.startPeriod = 1'b1;
          end
        end else begin
          strobe.advance = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stopPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != ST_RUN) begin
        stopPend <= 1'b0;
      end else if (state == ST_RUN && stopReq) begin
        stopPend <= 1'b1;
      end
    end
  end

  AST_RUN_UNTIL_END: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RUN && !periodEnd |=> state == ST_RUN); // R8

  AST_IDLE_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE && !cfgReady |=> state == ST_IDLE); // R5

  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ARMED && !extTrig |=> state != ST_RUN); // R9

endmodule

// File: rtl/rgt_dpath.sv
module rgt_dpath
  import rgt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rgt_strobe_t      strobe,
  input  logic [CNT_W-1:0] pendPeriod,
  input  logic [CNT_W-1:0] pendTxWidth,
  input  logic [CNT_W-1:0] pendGateDelay,
  input  logic [CNT_W-1:0] pendGateWidth,
  output logic             periodEnd,
  output logic             txEnable,
  output logic             rxGate,
  output logic             rangeStrobe
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] actPeriod;
  logic [CNT_W-1:0] actTxWidth;
  logic [CNT_W-1:0] actGateDelay;
  logic [CNT_W-1:0] actGateWidth;
  logic [SUM_W-1:0] gateEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= '0;
      actPeriod    <= CNT_W'(1);
      actTxWidth   <= '0;
      actGateDelay <= '0;
      actGateWidth <= '0;
    end else if (strobe.startPeriod) begin
      phase        <= '0;
      actPeriod    <= pendPeriod;
      actTxWidth   <= pendTxWidth;
      actGateDelay <= pendGateDelay;
      actGateWidth <= pendGateWidth;
    end else if (strobe.advance) begin
      phase <= phase + CNT_W'(1);
    end
  end

  assign gateEnd     = {1'b0, actGateDelay} + {1'b0, actGateWidth};
  assign periodEnd   = phase == (actPeriod - CNT_W'(1));
  assign txEnable    = strobe.gateOn && (phase < actTxWidth);
  assign rxGate      = strobe.gateOn && (phase >= actGateDelay)
                       && ({1'b0, phase} < gateEnd);
  assign rangeStrobe = strobe.gateOn && (phase == actGateDelay)
                       && (actGateWidth != '0);

  AST_TX_RX_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(txEnable && rxGate)); // R11

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.gateOn |-> !txEnable && !rxGate && !rangeStrobe); // R10

  AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gateOn |-> phase < actPeriod); // R1

  AST_STROBE_IN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    rangeStrobe |-> rxGate); // R4

  AST_ACT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gateOn && !strobe.startPeriod |=>
      $stable(actPeriod) && $stable(actTxWidth) && $stable(actGateDelay)); // R7

endmodule

// File: rtl/radar_gate_timer.sv
module radar_gate_timer
  import rgt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgTxWidth,
  input  logic [CNT_W-1:0] cfgGateDelay,
  input  logic [CNT_W-1:0] cfgGateWidth,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             extTrigEn,
  input  logic             extTrig,
  output logic             txEnable,
  output logic             rxGate,
  output logic             rangeStrobe,
  output logic             cfgError
);

  logic [CNT_W-1:0] pendPeriod;
  logic [CNT_W-1:0] pendTxWidth;
  logic [CNT_W-1:0] pendGateDelay;
  logic [CNT_W-1:0] pendGateWidth;
  logic             cfgReady;
  logic             periodEnd;
  rgt_strobe_t      strobe;

  rgt_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk           (clk),
    .rstN          (rstN),
    .cfgLoad       (cfgLoad),
    .inPeriod      (cfgPeriod),
    .inTxWidth     (cfgTxWidth),
    .inGateDelay   (cfgGateDelay),
    .inGateWidth   (cfgGateWidth),
    .pendPeriod    (pendPeriod),
    .pendTxWidth   (pendTxWidth),
    .pendGateDelay (pendGateDelay),
    .pendGateWidth (pendGateWidth),
    .cfgReady      (cfgReady),
    .cfgError      (cfgError)
  );

  rgt_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .extTrigEn (extTrigEn),
    .extTrig   (extTrig),
    .cfgReady  (cfgReady),
    .periodEnd (periodEnd),
    .strobe    (strobe)
  );

  rgt_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .pendPeriod    (pendPeriod),
    .pendTxWidth   (pendTxWidth),
    .pendGateDelay (pendGateDelay),
    .pendGateWidth (pendGateWidth),
    .periodEnd     (periodEnd),
    .txEnable      (txEnable),
    .rxGate        (rxGate),
    .rangeStrobe   (rangeStrobe)
  );

endmodule

// File: tb/radar_gate_timer_tb_top.sv
module radar_gate_timer_tb_top;

  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgLoad;
  logic [CW-1:0] cfgPeriod, cfgTxWidth, cfgGateDelay, cfgGateWidth;
  logic          startReq, stopReq, extTrigEn, extTrig;
  logic          txEnable, rxGate, rangeStrobe, cfgError;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  radar_gate_timer #(.CNT_W(CW)) dut_i (
    .clk, .rstN, .cfgLoad, .cfgPeriod, .cfgTxWidth, .cfgGateDelay,
    .cfgGateWidth, .startReq, .stopReq, .extTrigEn, .extTrig,
    .txEnable, .rxGate, .rangeStrobe, .cfgError
  );

  function automatic logic [2:0] expOut(longint unsigned ph, longint unsigned w,
                                        longint unsigned d, longint unsigned g);
    logic t, r, s;
    t = ph < w;
    r = (ph >= d) && (ph < d + g);
    s = (ph == d) && (g != 0);
    return {t, r, s};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Check outputs at this falling edge, then move to the next one
  task automatic stepOut(logic [2:0] exp, string req);
    chk(req, {29'b0, txEnable, rxGate, rangeStrobe}, {29'b0, exp});
    @(negedge clk);
  endtask

  task automatic loadCfg(logic [31:0] p, logic [31:0] w, logic [31:0] d, logic [31:0] g);
    cfgPeriod = p; cfgTxWidth = w; cfgGateDelay = d; cfgGateWidth = g;
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // R1 R2 R3 R4 R8: free run for n periods, stop asked at phase 0 of the last
  task automatic runFree(int unsigned p, int unsigned w, int unsigned d,
                         int unsigned g, int unsigned n);
    loadCfg(p, w, d, g);
    chk("R6 cfgError after good load", {31'b0, cfgError}, 32'd0);
    pulseStart();
    for (int unsigned i = 0; i < n * p; i++) begin
      stopReq = (i == (n - 1) * p);
      chk("R11 tx and rx overlap", {31'b0, txEnable & rxGate}, 32'd0);
      stepOut(expOut(i % p, w, d, g), "R1 R2 R3 R4 period waveform");
    end
    stopReq = 1'b0;
    repeat (3) stepOut(3'b000, "R8 idle after stop");
  endtask

  task automatic startIgnored(string req);
    pulseStart();
    repeat (3) stepOut(3'b000, req);
  endtask

  initial begin
    int unsigned p, w, d, g, n;
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgLoad = 1'b0; startReq = 1'b0; stopReq = 1'b0;
    extTrigEn = 1'b0; extTrig = 1'b0;
    cfgPeriod = '0; cfgTxWidth = '0; cfgGateDelay = '0; cfgGateWidth = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R10 cfgError after reset", {31'b0, cfgError}, 32'd0);
    stepOut(3'b000, "R10 outputs after reset");

    // R5: start with nothing loaded
    startIgnored("R5 start without config");

    // R5: each rule broken once
    loadCfg(8, 8, 8, 0);
    chk("R5 width not below period", {31'b0, cfgError}, 32'd1);
    startIgnored("R5 start after rejected width");
    loadCfg(8, 3, 2, 1);
    chk("R5 delay below width", {31'b0, cfgError}, 32'd1);
    startIgnored("R5 start after rejected delay");
    loadCfg(32'hFFFF_FFFF, 0, 32'hFFFF_FFF0, 32'h20);
    chk("R5 gate end wraps", {31'b0, cfgError}, 32'd1);
    startIgnored("R5 start after wrapped gate");
    loadCfg(10, 2, 6, 5);
    chk("R5 gate past period", {31'b0, cfgError}, 32'd1);

    // Directed corners
    runFree(1, 0, 0, 1, 3);   // gate held open, strobe each cycle
    runFree(5, 4, 4, 1, 2);   // gate right after transmit
    runFree(6, 0, 6, 0, 2);   // no pulses at all
    runFree(7, 1, 1, 6, 2);   // gate fills rest of period

    // Random sets within the rules
    for (int k = 0; k < 14; k++) begin
      p = 2 + $urandom % 39;
      w = $urandom % p;
      d = w + $urandom % (p - w + 1);
      g = $urandom % (p - d + 1);
      n = 2 + $urandom % 2;
      runFree(p, w, d, g, n);
    end

    // R7: new set mid-period, applied at the next period start
    loadCfg(10, 3, 4, 3);
    pulseStart();
    for (int i = 0; i < 10; i++) begin
      if (i == 2) begin
        cfgPeriod = 6; cfgTxWidth = 1; cfgGateDelay = 2; cfgGateWidth = 2;
        cfgLoad = 1'b1;
      end else begin
        cfgLoad = 1'b0;
      end
      stepOut(expOut(i, 3, 4, 3), "R7 current period keeps old set");
    end
    for (int i = 0; i < 6; i++) begin
      stopReq = (i == 0);
      stepOut(expOut(i, 1, 2, 2), "R7 next period uses new set");
    end
    stopReq = 1'b0;
    repeat (2) stepOut(3'b000, "R8 idle after stop");

    // R5: rejection while running ends the sequence at the period end
    loadCfg(8, 2, 3, 3);
    pulseStart();
    for (int i = 0; i < 8; i++) begin
      if (i == 1) begin
        cfgPeriod = 4; cfgTxWidth = 4; cfgGateDelay = 4; cfgGateWidth = 0;
        cfgLoad = 1'b1;
      end else begin
        cfgLoad = 1'b0;
      end
      stepOut(expOut(i, 2, 3, 3), "R5 period completes after rejection");
    end
    chk("R5 error flag while running", {31'b0, cfgError}, 32'd1);
    repeat (3) stepOut(3'b000, "R5 idle after rejection");

    // R9: triggered periods
    loadCfg(8, 2, 3, 2);
    extTrigEn = 1'b1;
    pulseStart();
    repeat (4) stepOut(3'b000, "R9 waiting for trigger");
    extTrig = 1'b1;
    stepOut(3'b000, "R9 trigger cycle");
    extTrig = 1'b0;
    for (int i = 0; i < 8; i++) stepOut(expOut(i, 2, 3, 2), "R9 triggered period");
    repeat (3) stepOut(3'b000, "R9 rearmed wait");
    extTrig = 1'b1;
    stepOut(3'b000, "R9 second trigger cycle");
    extTrig = 1'b0;
    for (int i = 0; i < 8; i++) stepOut(expOut(i, 2, 3, 2), "R9 second period");
    stopReq = 1'b1;
    stepOut(3'b000, "R9 stop while waiting");
    stopReq = 1'b0;
    extTrig = 1'b1;
    stepOut(3'b000, "R9 trigger after stop");
    extTrig = 1'b0;
    repeat (3) stepOut(3'b000, "R9 stays idle");
    extTrigEn = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule